// File: doc/BRIEF.md
# ROM Word Patch Unit

This block sits on the 16-bit read path between a processor and its boot ROM and lets up to four individual ROM words be replaced by other values without touching the ROM itself. Each of the four compare slots holds a word address and a replacement word. Once the unit is armed, any read whose word address matches a programmed slot returns that slot's replacement word, and the ROM's own data is discarded. Reads that match no slot return the ROM data unchanged.

The unit also controls the memory map. Before it is armed, a small ROM that belongs to the unit appears at address zero and the normal boot ROM is moved up to byte address 0x400000. Code running from the unit's ROM loads the slots one field at a time and then performs a single key write. That write enables the comparators, removes the unit's ROM from the map and places the boot ROM at address zero. Arming is one-way until the next reset, so the patch table cannot be changed after it has been armed.

The processor address `cpu_addr` is a word address that carries byte-address bits A23..A1. The two ROMs are external and answer combinationally through a chip select, an address and a data port. Register writes take effect at the next rising clock edge. The read data path is combinational from address to data.

Top module: `rom_patch_unit`

## Requirements
- R1: After reset the unit is unarmed and every slot is empty. If the unit is then armed with no slot written, every read returns the plain ROM data. A slot becomes live on the first write to any of its four registers.
- R2: While unarmed, a read at word address below 2^OWN_AW selects the unit's ROM (`own_cs`=1, `own_addr`=`cpu_addr` low bits). A read in the window starting at byte 0x400000 (word 0x200000) selects the boot ROM (`boot_cs`=1, `boot_addr`=offset). Any other read returns 0 with neither ROM selected.
- R3: A write of 0xFFFF to byte address 0x100020 (word 0x080010) arms the unit from the next clock edge on. A write of any other value to that address leaves the unit unarmed. Once armed, the unit stays armed until reset.
- R4: While armed, the boot ROM answers at word addresses below 2^BOOT_AW. The unit's ROM is never selected, and reads in the old boot ROM window return 0.
- R5: Slot n (0..3) has its registers at byte base 0x100000 + 8n. Offset +0 holds the replacement word. Offset +2 holds address bits A8..A1 in write data bits 7..0. Offset +4 holds A16..A9 in data bits 7..0. Offset +6 holds A23..A17 in data bits 6..0.
- R6: While armed, a read whose word address equals a live slot's address returns that slot's replacement word, even when the address maps to no ROM. A read of the neighbouring word is not patched.
- R7: When more than one live slot matches, the replacement word of the lowest-numbered slot is returned.
- R8: Once the unit is armed, writes to slot registers leave both the stored address and the replacement word unchanged.
- R9: Whenever `cpu_rd` is low, including during any write, `cpu_rdata` is 0 and neither ROM select is asserted.
- R10: While unarmed, a read at a programmed slot address returns the normal mapped data and is not patched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 23 | Word address (byte bits A23..A1) |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Read data returned to the processor |
| own_cs | output | 1 | Select for the unit's own ROM |
| own_addr | output | 16 | Word address into the unit's ROM |
| own_data | input | 16 | Data from the unit's ROM |
| boot_cs | output | 1 | Select for the boot ROM |
| boot_addr | output | 16 | Word address into the boot ROM |
| boot_data | input | 16 | Data from the boot ROM |

## Verification
The assertions assume that the processor never raises `cpu_rd` and `cpu_wr` in the same cycle. The stimulus keeps to this by issuing exactly one bus operation per cycle, either a read or a write. The checks on stuck arming and frozen slots assume that reset is the only way back to the unarmed state. The bench therefore returns the unit to that state only through a second reset, which it uses to test the empty-slot case.

// File: rtl/rom_patch_pkg.sv
package rom_patch_pkg;

    localparam int WADDR_W = 23;
    localparam int WORD_W  = 16;
    localparam int FIELD_REGS = 4;

    typedef struct packed {
        logic               live;
        logic [WADDR_W-1:0] addr;
        logic [WORD_W-1:0]  repl;
    } slot_t;

    typedef enum logic [1:0] {
        MAP_NONE = 2'd0,
        MAP_OWN  = 2'd1,
        MAP_BOOT = 2'd2
    } map_sel_e;

    typedef enum logic [1:0] {
        FLD_REPL = 2'd0,
        FLD_LO   = 2'd1,
        FLD_MID  = 2'd2,
        FLD_HI   = 2'd3
    } field_e;

    function automatic logic [WADDR_W-1:0] merge_field(
        input logic [WADDR_W-1:0] cur,
        input field_e             fld,
        input logic [7:0]         val
    );
        logic [WADDR_W-1:0] r;
        r = cur;
        case (fld)
            FLD_LO:  r[7:0]   = val;
            FLD_MID: r[15:8]  = val;
            FLD_HI:  r[22:16] = val[6:0];
            default: r = cur;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rom_patch_regs.sv
module rom_patch_regs
    import rom_patch_pkg::*;
#(
    parameter int                 SLOTS    = 4,
    parameter logic [WADDR_W-1:0] REG_BASE = 23'h080000,
    parameter logic [WORD_W-1:0]  ARM_KEY  = 16'hFFFF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [WADDR_W-1:0] cpu_addr,
    input  logic               cpu_wr,
    input  logic [WORD_W-1:0]  cpu_wdata,
    output slot_t [SLOTS-1:0]  slots,
    output logic               armed
);

    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam logic [WADDR_W-1:0] ARM_ADDR = REG_BASE + WADDR_W'(SLOTS * FIELD_REGS);

    logic [WADDR_W-1:0] off;
    logic               in_slots;
    logic [IDX_W-1:0]   idx;
    field_e             fld;
    logic               slot_we;

    assign off      = cpu_addr - REG_BASE;
    assign in_slots = (cpu_addr >= REG_BASE) && (cpu_addr < ARM_ADDR);
    assign idx      = off[2 +: IDX_W];
    assign fld      = field_e'(off[1:0]);
    assign slot_we  = cpu_wr && !armed && in_slots;

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slots[i] <= '0;
            end else if (slot_we && idx == IDX_W'(i)) begin
                slots[i].live <= 1'b1;
                if (fld == FLD_REPL)
                    slots[i].repl <= cpu_wdata;
                else
                    slots[i].addr <= merge_field(slots[i].addr, fld, cpu_wdata[7:0]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            armed <= 1'b0;
        else if (cpu_wr && cpu_addr == ARM_ADDR && cpu_wdata == ARM_KEY)
            armed <= 1'b1;
    end

endmodule

// File: rtl/rom_patch_match.sv
module rom_patch_match
    import rom_patch_pkg::*;
#(
    parameter int SLOTS = 4
) (
    input  slot_t [SLOTS-1:0]  slots,
    input  logic [WADDR_W-1:0] cpu_addr,
    input  logic               enable,
    output logic               hit,
    output logic [WORD_W-1:0]  repl
);

    logic [SLOTS-1:0] slot_hit;

    for (genvar i = 0; i < SLOTS; i++) begin : g_cmp
        assign slot_hit[i] = enable && slots[i].live && (slots[i].addr == cpu_addr);
    end

    // Scan from the top down so the lowest-numbered match is the one kept.
    always_comb begin
        repl = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (slot_hit[i])
                repl = slots[i].repl;
        end
    end

    assign hit = |slot_hit;

endmodule

// File: rtl/rom_patch_map.sv
module rom_patch_map
    import rom_patch_pkg::*;
#(
    parameter int                 OWN_AW    = 16,
    parameter int                 BOOT_AW   = 16,
    parameter logic [WADDR_W-1:0] BOOT_BASE = 23'h200000
) (
    input  logic               armed,
    input  logic [WADDR_W-1:0] cpu_addr,
    input  logic               cpu_rd,
    output logic               own_cs,
    output logic [OWN_AW-1:0]  own_addr,
    input  logic [WORD_W-1:0]  own_data,
    output logic               boot_cs,
    output logic [BOOT_AW-1:0] boot_addr,
    input  logic [WORD_W-1:0]  boot_data,
    output logic [WORD_W-1:0]  rom_rdata
);

    localparam int OWN_HI_W  = WADDR_W - OWN_AW;
    localparam int BOOT_HI_W = WADDR_W - BOOT_AW;

    logic     at_low_own;
    logic     at_low_boot;
    logic     at_high_boot;
    map_sel_e sel;

    assign at_low_own   = cpu_addr[WADDR_W-1:OWN_AW] == OWN_HI_W'(0);
    assign at_low_boot  = cpu_addr[WADDR_W-1:BOOT_AW] == BOOT_HI_W'(0);
    assign at_high_boot = cpu_addr[WADDR_W-1:BOOT_AW] == BOOT_BASE[WADDR_W-1:BOOT_AW];

    always_comb begin
        sel = MAP_NONE;
        if (cpu_rd) begin
            if (armed) begin
                if (at_low_boot) sel = MAP_BOOT;
            end else begin
                if (at_low_own)        sel = MAP_OWN;
                else if (at_high_boot) sel = MAP_BOOT;
            end
        end
    end

    assign own_cs    = (sel == MAP_OWN);
    assign boot_cs   = (sel == MAP_BOOT);
    assign own_addr  = cpu_addr[OWN_AW-1:0];
    assign boot_addr = cpu_addr[BOOT_AW-1:0];

    always_comb begin
        case (sel)
            MAP_OWN:  rom_rdata = own_data;
            MAP_BOOT: rom_rdata = boot_data;
            default:  rom_rdata = '0;
        endcase
    end

endmodule

// File: rtl/rom_patch_unit.sv
module rom_patch_unit
    import rom_patch_pkg::*;
#(
    parameter int                 SLOTS     = 4,
    parameter int                 OWN_AW    = 16,
    parameter int                 BOOT_AW   = 16,
    parameter logic [WADDR_W-1:0] REG_BASE  = 23'h080000,
    parameter logic [WADDR_W-1:0] BOOT_BASE = 23'h200000,
    parameter logic [WORD_W-1:0]  ARM_KEY   = 16'hFFFF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [22:0]        cpu_addr,
    input  logic               cpu_rd,
    input  logic               cpu_wr,
    input  logic [15:0]        cpu_wdata,
    output logic [15:0]        cpu_rdata,
    output logic               own_cs,
    output logic [OWN_AW-1:0]  own_addr,
    input  logic [15:0]        own_data,
    output logic               boot_cs,
    output logic [BOOT_AW-1:0] boot_addr,
    input  logic [15:0]        boot_data
);

    slot_t [SLOTS-1:0] slot_q;
    logic              armed_q;
    logic              hit;
    logic [WORD_W-1:0] repl;
    logic [WORD_W-1:0] rom_rdata;

    rom_patch_regs #(
        .SLOTS(SLOTS), .REG_BASE(REG_BASE), .ARM_KEY(ARM_KEY)
    ) u_regs (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .slots(slot_q), .armed(armed_q)
    );

    rom_patch_match #(.SLOTS(SLOTS)) u_match (
        .slots(slot_q), .cpu_addr(cpu_addr), .enable(armed_q && cpu_rd),
        .hit(hit), .repl(repl)
    );

    rom_patch_map #(
        .OWN_AW(OWN_AW), .BOOT_AW(BOOT_AW), .BOOT_BASE(BOOT_BASE)
    ) u_map (
        .armed(armed_q), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
        .own_cs(own_cs), .own_addr(own_addr), .own_data(own_data),
        .boot_cs(boot_cs), .boot_addr(boot_addr), .boot_data(boot_data),
        .rom_rdata(rom_rdata)
    );

    always_comb begin
        if (!cpu_rd)  cpu_rdata = '0;
        else if (hit) cpu_rdata = repl;
        else          cpu_rdata = rom_rdata;
    end

endmodule

// File: rtl/rom_patch_chk.sv
module rom_patch_chk
    import rom_patch_pkg::*;
#(
    parameter int SLOTS = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_rd,
    input logic [15:0]       cpu_rdata,
    input logic              own_cs,
    input logic              boot_cs,
    input logic              armed,
    input slot_t [SLOTS-1:0] slots
);

    // R1: reset leaves the unit unarmed with every slot empty
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!armed && slots == '0));

    // R3: arming is sticky until reset
    a_r3_arm_sticky: assert property (@(posedge clk) disable iff (rst)
        armed |=> armed);

    // R4: the unit's own ROM is gone once armed
    a_r4_own_dark: assert property (@(posedge clk) disable iff (rst)
        armed |-> !own_cs);

    // R8: slot contents frozen while armed
    a_r8_slots_frozen: assert property (@(posedge clk) disable iff (rst)
        armed |=> $stable(slots));

    // R9: quiet bus when no read is in progress
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !cpu_rd |-> (cpu_rdata == 16'h0 && !own_cs && !boot_cs));

    // R2: never both ROMs selected
    a_r2_single_select: assert property (@(posedge clk) disable iff (rst)
        $onehot0({own_cs, boot_cs}));

endmodule

bind rom_patch_unit rom_patch_chk #(.SLOTS(SLOTS)) u_chk (
    .clk(clk), .rst(rst), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata),
    .own_cs(own_cs), .boot_cs(boot_cs), .armed(armed_q), .slots(slot_q)
);

// File: tb/sim_rom_patch_unit.sv
module sim_rom_patch_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [22:0] cpu_addr = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [15:0] cpu_wdata = '0;
    logic [15:0] cpu_rdata;
    logic        own_cs, boot_cs;
    logic [15:0] own_addr, boot_addr;
    logic [15:0] own_data, boot_data;

    always #2 clk = ~clk;

    // ROM models
    assign own_data  = own_addr ^ 16'hA5A5;
    assign boot_data = boot_addr + 16'h1234;

    rom_patch_unit u0 (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
        .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .own_cs(own_cs), .own_addr(own_addr), .own_data(own_data),
        .boot_cs(boot_cs), .boot_addr(boot_addr), .boot_data(boot_data)
    );

    typedef struct {
        logic [15:0] d;
        logic        o;
        logic        b;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   n_cmp  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;

    localparam logic [22:0] REGB  = 23'h080000;
    localparam logic [22:0] ARMA  = 23'h080010;
    localparam logic [22:0] BOOTB = 23'h200000;

    function automatic logic [15:0] ownv(input logic [22:0] a);
        return a[15:0] ^ 16'hA5A5;
    endfunction
    function automatic logic [15:0] bootv(input logic [22:0] a);
        return a[15:0] + 16'h1234;
    endfunction

    // Monitor: compare in the middle of each cycle
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_cmp++;
            if (cpu_rdata !== e.d || own_cs !== e.o || boot_cs !== e.b) begin
                n_fail++;
                $display("FAIL %s: got data=%h own=%b boot=%b, expected data=%h own=%b boot=%b",
                         e.tag, cpu_rdata, own_cs, boot_cs, e.d, e.o, e.b);
            end
        end
    end

    task automatic t_idle();
        @(posedge clk); #1;
        cpu_rd = 1'b0; cpu_wr = 1'b0;
    endtask

    task automatic t_read(input logic [22:0] a, input logic [15:0] d,
                          input logic o, input logic b, input string tag);
        exp_t e;
        @(posedge clk); #1;
        cpu_addr = a; cpu_rd = 1'b1; cpu_wr = 1'b0;
        e.d = d; e.o = o; e.b = b; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic t_write(input logic [22:0] a, input logic [15:0] d, input string tag);
        exp_t e;
        @(posedge clk); #1;
        cpu_addr = a; cpu_wdata = d; cpu_rd = 1'b0; cpu_wr = 1'b1;
        e.d = 16'h0; e.o = 1'b0; e.b = 1'b0; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic prog_slot(input int n, input logic [22:0] t, input logic [15:0] r);
        logic [22:0] base;
        base = REGB + 23'(n * 4);
        t_write(base,          r,                 "R9 write repl");
        t_write(base + 23'd1, {8'h00, t[7:0]},   "R9 write lo");
        t_write(base + 23'd2, {8'h00, t[15:8]},  "R9 write mid");
        t_write(base + 23'd3, {9'h000, t[22:16]}, "R9 write hi");
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        cpu_rd = 1'b0; cpu_wr = 1'b0; rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    localparam logic [22:0] T0 = 23'h000123;
    localparam logic [22:0] T1 = 23'h300000;
    localparam logic [22:0] T2 = 23'h00ABCD;

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1/R2: reset state is the unarmed map
        t_read(23'h000005, ownv(23'h000005), 1'b1, 1'b0, "R1 R2 own ROM at zero after reset");
        t_read(BOOTB + 23'h10, bootv(23'h10), 1'b0, 1'b1, "R2 boot ROM at high base");
        t_read(REGB, 16'h0, 1'b0, 1'b0, "R2 unmapped reads zero");
        t_write(23'h000003, 16'h5555, "R9 write returns zero");

        // R5: program slots through their field registers
        prog_slot(0, T0, 16'hBEEF);
        prog_slot(1, T1, 16'h1111);
        prog_slot(2, T2, 16'h2222);
        prog_slot(3, T2, 16'h3333);

        // R10: no patching while unarmed
        t_read(T0, ownv(T0), 1'b1, 1'b0, "R10 unarmed read not patched");

        // R3: wrong key does not arm
        t_write(ARMA, 16'h1234, "R9 wrong key write");
        t_read(23'h000005, ownv(23'h000005), 1'b1, 1'b0, "R3 wrong key leaves unarmed");

        // R3: correct key arms
        t_write(ARMA, 16'hFFFF, "R9 arm write");
        t_read(23'h000005, bootv(23'h000005), 1'b0, 1'b1, "R3 R4 boot ROM at zero after arm");
        t_read(BOOTB + 23'h10, 16'h0, 1'b0, 1'b0, "R4 old boot window empty");

        // R5/R6: patches
        t_read(T0, 16'hBEEF, 1'b0, 1'b1, "R5 R6 slot0 patch");
        t_read(T0 + 23'd1, bootv(T0 + 23'd1), 1'b0, 1'b1, "R6 neighbour unpatched");
        t_read(T1, 16'h1111, 1'b0, 1'b0, "R5 R6 patch on unmapped address");
        t_read(T2, 16'h2222, 1'b0, 1'b1, "R7 lowest slot wins");

        // R8: slot writes ignored once armed
        t_write(REGB, 16'h0000, "R9 write after arm");
        t_write(REGB + 23'd1, 16'h0044, "R9 write after arm");
        t_read(T0, 16'hBEEF, 1'b0, 1'b1, "R8 slot0 unchanged after writes");
        t_read(23'h000044, bootv(23'h000044), 1'b0, 1'b1, "R8 new address not patched");

        // R9: write to a patched address while armed
        t_write(T0, 16'h7777, "R9 write on patched address");
        t_read(T0, 16'hBEEF, 1'b0, 1'b1, "R9 patch intact after bus write");

        // R1: fresh reset, arm with empty slots
        do_reset();
        t_read(23'h000000, ownv(23'h0), 1'b1, 1'b0, "R1 unarmed after second reset");
        t_write(ARMA, 16'hFFFF, "R9 arm write");
        t_read(23'h000000, bootv(23'h0), 1'b0, 1'b1, "R1 empty slots leave address 0 alone");
        t_read(T0, bootv(T0), 1'b0, 1'b1, "R1 old slot address cleared");

        t_idle();
        t_idle();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end

endmodule